// File: doc/BRIEF.md
# Transmit Frame Statistics Counters

This block keeps the transmit-side statistics of an Ethernet MAC. When the transmit engine finishes a frame, or gives it up, it presents a one-cycle outcome record. The record carries the number of collisions seen, a deferral flag, a late-collision flag, a carrier-loss flag, a DMA underrun flag and an SQE test failure flag. The block sorts that record into a set of saturating counters. The sorting follows fixed rules: an underrun suppresses every other counter, and a late collision is also counted among ordinary collisions.

A host reads any counter through a simple registered read port. A counter clears when it is read. A read and an increment that hit the same counter in the same cycle lose no event: the read returns the old value and the counter restarts at one. Counter widths and the collision attempt limit are parameters.

Top module: `tx_stats`

## Requirements
- R1: After reset every counter reads zero.
- R2: A record without underrun and with a collision count below COL_LIMIT (16 by default) increments the frames-sent counter (address 0x00, W_OK bits, default 24).
- R3: A record without underrun and with exactly one collision increments the single-collision counter (address 0x01, W_MID bits, default 16).
- R4: A record without underrun and with 2 to COL_LIMIT-1 collisions increments the multiple-collision counter (address 0x02, W_MID bits).
- R5: A record without underrun and with a collision count of COL_LIMIT or more increments the excessive-collision counter (address 0x05, W_SHORT bits, default 8). It does not touch the frames-sent, single-collision or multiple-collision counters.
- R6: A record without underrun and with the late flag set increments the late-collision counter (address 0x04, W_SHORT bits). The collision-count rules of R3 to R5 still apply to the same frame.
- R7: A record without underrun, with the deferral flag set and zero collisions, increments the deferred counter (address 0x03, W_MID bits). With any collision the deferral flag is ignored.
- R8: A record without underrun, with the carrier-loss flag set, half_duplex high and a collision count below COL_LIMIT, increments the carrier-sense-error counter (address 0x06, W_SHORT bits). In full duplex, or on excessive collisions, the flag has no effect.
- R9: A record without underrun and with the SQE failure flag set increments the SQE-error counter (address 0x08, W_SHORT bits).
- R10: A record with the underrun flag set increments only the underrun counter (address 0x07, W_SHORT bits), whatever its other fields hold.
- R11: Every counter stops at its all-ones value and never wraps.
- R12: A read clears the addressed counter. If an increment of that counter arrives in the same cycle, the read returns the value before the increment and the counter becomes 1.
- R13: rd_data carries the addressed counter, zero-extended to 32 bits, in the cycle after rd_en is high. Addresses 0x09 and above read zero. rd_data is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done | input | 1 | Outcome record valid for one cycle |
| tx_col_cnt | input | CW ($clog2(COL_LIMIT+1), 5) | Collisions seen by the frame |
| tx_deferred | input | 1 | First attempt deferred by carrier sense |
| tx_late_col | input | 1 | Collision after the slot time |
| tx_crs_lost | input | 1 | Carrier not seen and held one slot time into transmission |
| tx_underrun | input | 1 | Frame abandoned on DMA underrun |
| tx_sqe_fail | input | 1 | No COL within a slot time after transmit enable fell |
| half_duplex | input | 1 | Link runs half duplex |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Counter word address |
| rd_data | output | 32 | Read data, zero-extended, one cycle after the strobe |

## Verification
The bench builds the block with narrow counters: 5 bits for frames sent, 4 bits for the collision and deferred group, and 3 bits for the error group. It keeps the default attempt limit of 16. With these widths, saturation of both a wide and a narrow counter is reached in a few dozen frames. The full 1 to 16 collision range is still exercised. The narrow widths also make the zero-extension of rd_data visible in the upper bits.

// File: rtl/tx_stats_pkg.sv
package tx_stats_pkg;
  localparam int NUM_CNT = 9;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  // counter index equals read word address
  typedef enum int unsigned {
    CNT_OK   = 0,
    CNT_SGL  = 1,
    CNT_MUL  = 2,
    CNT_DEF  = 3,
    CNT_LATE = 4,
    CNT_EXC  = 5,
    CNT_CSE  = 6,
    CNT_UND  = 7,
    CNT_SQE  = 8
  } cnt_idx_e;
endpackage

// File: rtl/tx_stats_classify.sv
module tx_stats_classify
  import tx_stats_pkg::*;
#(
  parameter int COL_LIMIT = 16,
  parameter int CW        = 5
) (
  input  logic               valid,
  input  logic [CW-1:0]      col_cnt,
  input  logic               deferred,
  input  logic               late_col,
  input  logic               crs_lost,
  input  logic               underrun,
  input  logic               sqe_fail,
  input  logic               half_duplex,
  output logic [NUM_CNT-1:0] inc
);
  logic sent;
  logic zero_col;

  always_comb begin
    sent     = (col_cnt < CW'(COL_LIMIT));
    zero_col = (col_cnt == '0);
    inc      = '0;
    if (valid) begin
      if (underrun) begin
        inc[CNT_UND] = 1'b1;
      end else begin
        inc[CNT_OK]   = sent;
        inc[CNT_SGL]  = (col_cnt == CW'(1));
        inc[CNT_MUL]  = sent && (col_cnt >= CW'(2));
        inc[CNT_EXC]  = !sent;
        inc[CNT_LATE] = late_col;
        inc[CNT_DEF]  = deferred && zero_col;
        inc[CNT_CSE]  = crs_lost && half_duplex && sent;
        inc[CNT_SQE]  = sqe_fail;
      end
    end
  end
endmodule

// File: rtl/tx_stats_counter.sv
module tx_stats_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);
  logic [W-1:0] value_nxt;
  logic         at_max;
  logic         upd_en;

  always_comb begin
    at_max    = &value;
    upd_en    = inc || clr;
    value_nxt = value;
    if (clr) begin
      value_nxt = inc ? W'(1) : '0;
    end else if (inc && !at_max) begin
      value_nxt = value + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (upd_en) begin
      value <= value_nxt;
    end
  end
endmodule

// File: rtl/tx_stats_rdport.sv
module tx_stats_rdport
  import tx_stats_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]  vals,
  output logic [NUM_CNT-1:0]              clr,
  output logic [DATA_W-1:0]               rd_data
);
  localparam int IDX_W = $clog2(NUM_CNT);

  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    hit      = rd_en && (rd_addr < ADDR_W'(NUM_CNT));
    idx      = rd_addr[IDX_W-1:0];
    data_nxt = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      clr[k] = hit && (idx == IDX_W'(k));
      if (clr[k]) data_nxt = vals[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= data_nxt;
    end
  end
endmodule

// File: rtl/tx_stats.sv
module tx_stats
  import tx_stats_pkg::*;
#(
  parameter int W_OK      = 24,
  parameter int W_MID     = 16,
  parameter int W_SHORT   = 8,
  parameter int COL_LIMIT = 16,
  localparam int CW       = $clog2(COL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_done,
  input  logic [CW-1:0]     tx_col_cnt,
  input  logic              tx_deferred,
  input  logic              tx_late_col,
  input  logic              tx_crs_lost,
  input  logic              tx_underrun,
  input  logic              tx_sqe_fail,
  input  logic              half_duplex,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_CNT-1:0]             inc;
  logic [NUM_CNT-1:0]             clr;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_vals;

  tx_stats_classify #(
    .COL_LIMIT (COL_LIMIT),
    .CW        (CW)
  ) u_classify (
    .valid       (tx_done),
    .col_cnt     (tx_col_cnt),
    .deferred    (tx_deferred),
    .late_col    (tx_late_col),
    .crs_lost    (tx_crs_lost),
    .underrun    (tx_underrun),
    .sqe_fail    (tx_sqe_fail),
    .half_duplex (half_duplex),
    .inc         (inc)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int W = (i == int'(CNT_OK)) ? W_OK :
                       ((i == int'(CNT_SGL)) || (i == int'(CNT_MUL)) ||
                        (i == int'(CNT_DEF))) ? W_MID : W_SHORT;
    logic [W-1:0] val;

    tx_stats_counter #(.W(W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc[i]),
      .clr   (clr[i]),
      .value (val)
    );

    assign cnt_vals[i] = DATA_W'(val);
  end

  tx_stats_rdport u_rdport (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .vals    (cnt_vals),
    .clr     (clr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/tx_stats_chk.sv
module tx_stats_chk
  import tx_stats_pkg::*;
#(
  parameter int COL_LIMIT = 16,
  parameter int CW        = 5
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tx_done,
  input logic [CW-1:0]                   tx_col_cnt,
  input logic                            tx_underrun,
  input logic                            rd_en,
  input logic [DATA_W-1:0]               rd_data,
  input logic [NUM_CNT-1:0]              inc,
  input logic [NUM_CNT-1:0]              clr,
  input logic [NUM_CNT-1:0][DATA_W-1:0]  cnt_vals
);
  // R10
  underrun_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_underrun) |-> (inc == (NUM_CNT'(1) << CNT_UND)));

  // R5
  excess_not_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_underrun && (tx_col_cnt >= CW'(COL_LIMIT)))
      |-> (!inc[CNT_OK] && !inc[CNT_SGL] && !inc[CNT_MUL] && inc[CNT_EXC]));

  // R13
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  // R12
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt_chk
    // R11
    sat_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr[k] |=> (cnt_vals[k] >= $past(cnt_vals[k])));

    // R12
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[k] |=> (cnt_vals[k] == DATA_W'($past(inc[k]))));

    // R12
    read_returns_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[k] |=> (rd_data == $past(cnt_vals[k])));
  end
endmodule

bind tx_stats tx_stats_chk #(
  .COL_LIMIT (COL_LIMIT),
  .CW        (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_done     (tx_done),
  .tx_col_cnt  (tx_col_cnt),
  .tx_underrun (tx_underrun),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .inc         (inc),
  .clr         (clr),
  .cnt_vals    (cnt_vals)
);

// File: tb/tx_stats_test.sv
module tx_stats_test;
  localparam int W_OK    = 5;
  localparam int W_MID   = 4;
  localparam int W_SHORT = 3;
  localparam int LIMIT   = 16;
  localparam int CW      = $clog2(LIMIT + 1);

  logic          clk;
  logic          rst_n;
  logic          tx_done;
  logic [CW-1:0] tx_col_cnt;
  logic          tx_deferred, tx_late_col, tx_crs_lost;
  logic          tx_underrun, tx_sqe_fail, half_duplex;
  logic          rd_en;
  logic [7:0]    rd_addr;
  logic [31:0]   rd_data;

  int n_tests;
  int n_fail;
  int cycles;
  bit done;

  tx_stats #(
    .W_OK      (W_OK),
    .W_MID     (W_MID),
    .W_SHORT   (W_SHORT),
    .COL_LIMIT (LIMIT)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_done     (tx_done),
    .tx_col_cnt  (tx_col_cnt),
    .tx_deferred (tx_deferred),
    .tx_late_col (tx_late_col),
    .tx_crs_lost (tx_crs_lost),
    .tx_underrun (tx_underrun),
    .tx_sqe_fail (tx_sqe_fail),
    .half_duplex (half_duplex),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input int col, input bit def, input bit late, input bit crs,
                      input bit und, input bit sqe);
    @(negedge clk);
    tx_done     = 1'b1;
    tx_col_cnt  = CW'(col);
    tx_deferred = def;
    tx_late_col = late;
    tx_crs_lost = crs;
    tx_underrun = und;
    tx_sqe_fail = sqe;
    @(negedge clk);
    tx_done = 1'b0; tx_deferred = 1'b0; tx_late_col = 1'b0;
    tx_crs_lost = 1'b0; tx_underrun = 1'b0; tx_sqe_fail = 1'b0;
    tx_col_cnt = '0;
  endtask

  task automatic rd(input int addr, output logic [31:0] val);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 8'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    val   = rd_data;
  endtask

  // reads every counter in address order (clearing them) and compares
  task automatic expect_all(input string req, input int unsigned exp [9]);
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(a, v);
      chk($sformatf("%s addr %0d", req, a), v, exp[a]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    expect_all("R1 reset", '{0, 0, 0, 0, 0, 0, 0, 0, 0});
    rd(9, v);
    chk("R13 unmapped 0x09", v, 0);
    rd(8'hff, v);
    chk("R13 unmapped 0xff", v, 0);
  endtask

  task automatic t_clean;
    send(0, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0);
    expect_all("R2 clean frames", '{2, 0, 0, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_single;
    send(1, 0, 0, 0, 0, 0);
    expect_all("R3 single collision", '{1, 1, 0, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_multi;
    send(2, 0, 0, 0, 0, 0);
    send(15, 0, 0, 0, 0, 0);
    expect_all("R4 multiple collisions", '{2, 0, 2, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_excess;
    send(16, 0, 0, 0, 0, 0);
    expect_all("R5 excessive collisions", '{0, 0, 0, 0, 0, 1, 0, 0, 0});
  endtask

  task automatic t_late;
    send(1, 0, 1, 0, 0, 0);
    send(4, 0, 1, 0, 0, 0);
    expect_all("R6 late collision", '{2, 1, 1, 0, 2, 0, 0, 0, 0});
  endtask

  task automatic t_defer;
    send(0, 1, 0, 0, 0, 0);
    send(3, 1, 0, 0, 0, 0);
    expect_all("R7 deferred", '{2, 0, 1, 1, 0, 0, 0, 0, 0});
  endtask

  task automatic t_cse;
    half_duplex = 1'b1;
    send(0, 0, 0, 1, 0, 0);
    send(16, 0, 0, 1, 0, 0);
    expect_all("R8 carrier loss half duplex", '{1, 0, 0, 0, 0, 1, 1, 0, 0});
    half_duplex = 1'b0;
    send(0, 0, 0, 1, 0, 0);
    expect_all("R8 carrier loss full duplex ignored", '{1, 0, 0, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_sqe;
    send(0, 0, 0, 0, 0, 1);
    expect_all("R9 SQE error", '{1, 0, 0, 0, 0, 0, 0, 0, 1});
  endtask

  task automatic t_underrun;
    half_duplex = 1'b1;
    send(3, 1, 1, 1, 1, 1);
    send(16, 0, 0, 0, 1, 0);
    half_duplex = 1'b0;
    expect_all("R10 underrun exclusive", '{0, 0, 0, 0, 0, 0, 0, 2, 0});
  endtask

  task automatic t_sat;
    int n;
    n = 40;
    for (int i = 0; i < n; i++) send(0, 0, 0, 0, 0, 1);
    expect_all("R11 saturation",
               '{(1 << W_OK) - 1, 0, 0, 0, 0, 0, 0, 0, (1 << W_SHORT) - 1});
  endtask

  task automatic t_coinc;
    logic [31:0] v;
    send(0, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h00;
    tx_done = 1'b1; tx_col_cnt = '0;
    @(negedge clk);
    rd_en = 1'b0; tx_done = 1'b0;
    chk("R12 coincident read returns old value", rd_data, 3);
    @(negedge clk);
    chk("R13 rd_data zero after idle cycle", rd_data, 0);
    rd(0, v);
    chk("R12 counter restarts at one", v, 1);
    rd(0, v);
    chk("R12 read clears", v, 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cycles = 0; done = 0;
    rst_n = 1'b0;
    tx_done = 1'b0; tx_col_cnt = '0; tx_deferred = 1'b0; tx_late_col = 1'b0;
    tx_crs_lost = 1'b0; tx_underrun = 1'b0; tx_sqe_fail = 1'b0;
    half_duplex = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R13 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_multi();
    t_excess();
    t_late();
    t_defer();
    t_cse();
    t_sqe();
    t_underrun();
    t_sat();
    t_coinc();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule